// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers a build-time number of external interrupt request lines plus one non-maskable input, and keeps a pending bit, an enable bit, an active bit, a trigger mode and a two-bit priority for every line. From that state it presents to the processor core the one request that should run next, together with its line number. The core accepts the presented request with a one-cycle acknowledge, which moves the line from pending to active. When its handler finishes, the core gives a one-cycle exit strobe that retires the most urgent active handler.

Software reaches the state through a small write and read port. It can set or clear enables, set or clear pending bits, choose level or pulse triggering per line, and program priorities. The presented request is decoded combinationally from registered state. A request therefore appears one clock after it becomes eligible, however many other lines are asserted.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The parameter NUM_IRQ takes one of 1, 2, 4, 8, 16, 24 or 32. External lines are numbered 0 to NUM_IRQ-1.
- R2: Each line carries a 2-bit priority, and a lower value means more urgent. Among presentable lines of equal priority, the lowest line number is presented.
- R3: The non-maskable input has no enable. Once captured it is presented (req_nmi=1, req_id=0) ahead of every external line. While its handler is active, nothing else is presented.
- R4: A pulse-mode line (mode bit 0) captures an input that is high for a single cycle as pending. The pending bit stays set after the input drops.
- R5: A level-mode line (mode bit 1) is not set pending while its handler is active. If its input is still high after the exit, it is set pending again on the following clock.
- R6: A pulse-mode line is pending again after its exit only if a new pulse arrived while it was active.
- R7: An external line is presented only if it is pending, enabled, and strictly more urgent than the most urgent active handler. With no handler active, any priority qualifies.
- R8: Software set-pending and clear-pending writes take effect on the next clock. A hardware request in the same cycle as a clear leaves the line pending.
- R9: An acknowledge clears the presented line's pending bit and sets its active bit on the same edge. An exit clears the active non-maskable handler if there is one; otherwise it clears the most urgent active external handler (ties go to the lowest number). An acknowledge while nothing is presented has no effect.
- R10: A request appears at the outputs exactly one clock edge after the edge that records it as pending, whatever the other lines are doing.
- R11: After reset all enables, pending bits, active bits, modes and priorities read 0, and no request is presented.
- R12: Register addresses, one bit per line (bit n is line n):
  - 0: enable set (write 1s), reads the enables.
  - 1: enable clear, reads the enables.
  - 2: pending set, reads the pending bits.
  - 3: pending clear, reads the pending bits.
  - 4: active bits, read only; writes have no effect.
  - 5: mode, 1 = level, read and write.
  - 6: priorities of lines 0 to 15, line n at bits 2n+1:2n.
  - 7: priorities of lines 16 to 31, line n at bits 2(n-16)+1:2(n-16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQ | External request lines |
| nmi_in | input | 1 | Non-maskable request |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_valid | output | 1 | A request is presented |
| req_nmi | output | 1 | The presented request is the non-maskable one |
| req_id | output | IDW | Presented external line number |
| cpu_ack | input | 1 | Core takes the presented request |
| cpu_exit | input | 1 | Core leaves its current handler |

## Verification
The bench builds the block with NUM_IRQ set to 24. This is a count that is not a power of two, so line numbers are not dense in the id width. It also puts eight lines into the upper priority word, which exercises the split between the two priority addresses and the line 15 to 16 boundary. Twenty-four lines leave room for nesting three handler levels under a pending non-maskable request, and for ties between distant line numbers.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_IRQ = 32,
  localparam int IDW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic               nmi_in,
  input  logic               cfg_wr,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               req_valid,
  output logic               req_nmi,
  output logic [IDW-1:0]     req_id,
  input  logic               cpu_ack,
  input  logic               cpu_exit
);
  localparam int PW = 2 * NUM_IRQ;

  typedef struct packed {
    logic           hit;
    logic [IDW-1:0] id;
    logic [2:0]     urg;
  } pick_t;

  logic [NUM_IRQ-1:0] en_q, pend_q, act_q, lvl_q;
  logic [PW-1:0]      prio_q, prio_n;
  logic               nmi_pend_q, nmi_act_q;

  function automatic pick_t pick(input logic [NUM_IRQ-1:0] m, input logic [PW-1:0] p);
    pick_t r;
    r.hit = 1'b0;
    r.id  = '0;
    r.urg = 3'd4;
    for (int i = NUM_IRQ - 1; i >= 0; i--)
      if (m[i] && ({1'b0, p[2*i +: 2]} <= r.urg)) begin
        r.hit = 1'b1;
        r.id  = IDW'(i);
        r.urg = {1'b0, p[2*i +: 2]};
      end
    return r;
  endfunction

  pick_t cand, top;
  assign cand = pick(pend_q & en_q, prio_q);
  assign top  = pick(act_q, prio_q);

  assign req_nmi   = nmi_pend_q & ~nmi_act_q;
  assign req_valid = req_nmi | (~nmi_act_q & cand.hit & (cand.urg < top.urg));
  assign req_id    = req_nmi ? '0 : cand.id;

  logic ack_ext, ack_nmi, exit_nmi;
  logic [NUM_IRQ-1:0] ack_vec, exit_vec, sw_set, sw_clr, hw_set, wmask;

  assign ack_ext  = cpu_ack & req_valid & ~req_nmi;
  assign ack_nmi  = cpu_ack & req_nmi;
  assign exit_nmi = cpu_exit & nmi_act_q;
  assign ack_vec  = ack_ext ? (NUM_IRQ'(1) << cand.id) : '0;
  assign exit_vec = (cpu_exit & ~nmi_act_q & top.hit) ? (NUM_IRQ'(1) << top.id) : '0;

  assign wmask  = cfg_wdata[NUM_IRQ-1:0];
  assign sw_set = (cfg_wr && cfg_addr == 3'd2) ? wmask : '0;
  assign sw_clr = (cfg_wr && cfg_addr == 3'd3) ? wmask : '0;
  assign hw_set = (irq_in & lvl_q & ~act_q & ~ack_vec) | (irq_in & ~lvl_q);

  always_comb begin
    prio_n = prio_q;
    for (int i = 0; i < NUM_IRQ; i++)
      if (cfg_wr && cfg_addr == ((i < 16) ? 3'd6 : 3'd7))
        prio_n[2*i +: 2] = cfg_wdata[(2*i) % 32 +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= '0;
      pend_q     <= '0;
      act_q      <= '0;
      lvl_q      <= '0;
      prio_q     <= '0;
      nmi_pend_q <= 1'b0;
      nmi_act_q  <= 1'b0;
    end else begin
      if (cfg_wr && cfg_addr == 3'd0) en_q <= en_q | wmask;
      if (cfg_wr && cfg_addr == 3'd1) en_q <= en_q & ~wmask;
      if (cfg_wr && cfg_addr == 3'd5) lvl_q <= wmask;
      prio_q     <= prio_n;
      pend_q     <= ((pend_q | sw_set) & ~sw_clr & ~ack_vec) | hw_set;
      act_q      <= (act_q & ~exit_vec) | ack_vec;
      nmi_pend_q <= (nmi_pend_q | (nmi_in & ~nmi_act_q)) & ~ack_nmi;
      nmi_act_q  <= (nmi_act_q & ~exit_nmi) | ack_nmi;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      3'd0, 3'd1: cfg_rdata[NUM_IRQ-1:0] = en_q;
      3'd2, 3'd3: cfg_rdata[NUM_IRQ-1:0] = pend_q;
      3'd4:       cfg_rdata[NUM_IRQ-1:0] = act_q;
      3'd5:       cfg_rdata[NUM_IRQ-1:0] = lvl_q;
      default:
        for (int i = 0; i < NUM_IRQ; i++)
          if ((i < 16) == (cfg_addr == 3'd6))
            cfg_rdata[(2*i) % 32 +: 2] = prio_q[2*i +: 2];
    endcase
  end

  initial begin
    a_r1_legal_count: assert (NUM_IRQ inside {1, 2, 4, 8, 16, 24, 32})
      else $error("NUM_IRQ out of the legal set");
  end

  a_r9_ack_activates: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_valid && !req_nmi) |=> act_q[$past(req_id)]);

  a_r9_nmi_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && req_nmi) |=> (nmi_act_q && !nmi_pend_q));

  a_r9_nmi_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_exit && nmi_act_q) |=> !nmi_act_q);

  a_r7_presentable: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_nmi) |-> (en_q[req_id] && pend_q[req_id] && !nmi_act_q));

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    a_r4_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_in[g] && !lvl_q[g]) |=> pend_q[g]);

    a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == 3'd3 && cfg_wdata[g] && !irq_in[g]) |=> !pend_q[g]);

    a_r5_level_held_off: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q[g] && act_q[g] && !pend_q[g] && !(cfg_wr && cfg_addr == 3'd2 && cfg_wdata[g]))
        |=> !pend_q[g]);
  end
endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic nmi = 1'b0, wr = 1'b0, ack = 1'b0, ex = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic req_valid, req_nmi;
  logic [IW-1:0] req_id;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  prio_irq_ctrl #(.NUM_IRQ(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq), .nmi_in(nmi),
    .cfg_wr(wr), .cfg_addr(addr), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .req_valid(req_valid), .req_nmi(req_nmi), .req_id(req_id),
    .cpu_ack(ack), .cpu_exit(ex));

  logic [N-1:0] m_en = '0, m_pend = '0, m_act = '0, m_mode = '0;
  logic [2*N-1:0] m_prio = '0;
  logic m_np = 1'b0, m_na = 1'b0;

  function automatic void m_pick(input logic [N-1:0] m, output logic hit, output int id, output int urg);
    hit = 1'b0; id = 0; urg = 4;
    for (int i = 0; i < N; i++)
      if (m[i] && int'(m_prio[2*i +: 2]) < urg) begin
        hit = 1'b1; id = i; urg = int'(m_prio[2*i +: 2]);
      end
  endfunction

  function automatic void m_present(output logic v, output logic nm, output int id);
    logic ch, ah; int cu, au, aid;
    m_pick(m_pend & m_en, ch, id, cu);
    m_pick(m_act, ah, aid, au);
    nm = m_np && !m_na;
    v  = nm || (!m_na && ch && cu < au);
    if (nm) id = 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0, 3'd1: r[N-1:0] = m_en;
      3'd2, 3'd3: r[N-1:0] = m_pend;
      3'd4: r[N-1:0] = m_act;
      3'd5: r[N-1:0] = m_mode;
      3'd6: for (int i = 0; i < 16; i++) r[2*i +: 2] = m_prio[2*i +: 2];
      default: for (int i = 16; i < N; i++) r[2*(i-16) +: 2] = m_prio[2*i +: 2];
    endcase
    return r;
  endfunction

  task automatic step(input string tag);
    logic ev, en, ah;
    int eid, aid, au;
    logic [N-1:0] ackv, exv, sws, swc, hw, nen, nmode, npend, nact;
    logic [2*N-1:0] nprio;
    logic ack_e, ack_n, nnp, nna;
    m_present(ev, en, eid);
    n_chk++;
    if (req_valid !== ev || req_nmi !== en || (ev && !en && req_id !== IW'(eid))) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b nmi=%0b id=%0d, expected valid=%0b nmi=%0b id=%0d",
               tag, req_valid, req_nmi, req_id, ev, en, eid);
    end
    ack_e = ack && ev && !en;
    ack_n = ack && en;
    ackv  = ack_e ? (N'(1) << eid) : '0;
    m_pick(m_act, ah, aid, au);
    exv   = (ex && !m_na && ah) ? (N'(1) << aid) : '0;
    nna   = (m_na && !ex) || ack_n;
    nnp   = (m_np || (nmi && !m_na)) && !ack_n;
    sws   = (wr && addr == 3'd2) ? wdata[N-1:0] : '0;
    swc   = (wr && addr == 3'd3) ? wdata[N-1:0] : '0;
    for (int i = 0; i < N; i++)
      hw[i] = m_mode[i] ? (irq[i] && !m_act[i] && !ackv[i]) : irq[i];
    npend = ((m_pend | sws) & ~swc & ~ackv) | hw;
    nact  = (m_act & ~exv) | ackv;
    nen   = m_en;
    if (wr && addr == 3'd0) nen = m_en | wdata[N-1:0];
    if (wr && addr == 3'd1) nen = m_en & ~wdata[N-1:0];
    nmode = (wr && addr == 3'd5) ? wdata[N-1:0] : m_mode;
    nprio = m_prio;
    for (int i = 0; i < N; i++)
      if (wr && ((i < 16 && addr == 3'd6) || (i >= 16 && addr == 3'd7)))
        nprio[2*i +: 2] = wdata[2*(i % 16) +: 2];
    @(posedge clk);
    m_en = nen; m_pend = npend; m_act = nact; m_mode = nmode; m_prio = nprio;
    m_np = nnp; m_na = nna;
    @(negedge clk);
    wr = 1'b0; ack = 1'b0; ex = 1'b0;
    #1;
  endtask

  task automatic rd_check(input logic [2:0] a, input string tag);
    logic [31:0] exp;
    addr = a;
    #1;
    exp = m_read(a);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: addr %0d got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] a, input logic [31:0] d, input string tag);
    wr = 1'b1; addr = a; wdata = d;
    step(tag);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (R10): got no finish, expected end of run");
    summary();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    step("R11 reset no request");
    for (int a = 0; a < 8; a++) rd_check(3'(a), "R11 reset readback");

    wr_cfg(3'd0, 32'h00FF_FFFF, "R12 enable set");
    rd_check(3'd0, "R12 enable readback");
    wr_cfg(3'd4, 32'hFFFF_FFFF, "R12 active write");
    rd_check(3'd4, "R12 active ignores writes");
    wr_cfg(3'd6, 32'hFFFF_FFFF, "R12 prio low word");
    wr_cfg(3'd7, 32'hFFFF_FFFF, "R12 prio high word");
    rd_check(3'd6, "R12 prio low readback");
    rd_check(3'd7, "R12 prio high readback");

    irq = N'(1) << 3; step("R4 pulse sampled");
    irq = '0;          step("R4 pending presented");
    rd_check(3'd2, "R4 pending held after drop");

    irq = (N'(1) << 9) | (N'(1) << 5); step("R2 pulses");
    irq = '0;                          step("R2 tie goes to lowest number");
    wr_cfg(3'd6, 32'hFFFF_FFFF & ~(32'h2 << 18), "R2 line 9 to prio 1");
    step("R2 more urgent wins");
    wr_cfg(3'd7, 32'hFFFF_FFFF & ~(32'h3 << 8), "R2 line 20 to prio 0");
    wr_cfg(3'd2, 32'h1 << 20, "R8 software set");
    step("R8 set visible next clock");
    wr_cfg(3'd1, 32'h1 << 20, "R7 disable line 20");
    step("R7 disabled not presented");

    ack = 1'b1; step("R9 ack line 9");
    rd_check(3'd4, "R9 active set");
    rd_check(3'd2, "R9 pending cleared");
    step("R7 lower priority cannot preempt");
    wr_cfg(3'd0, 32'h1 << 20, "R7 enable line 20");
    step("R7 more urgent preempts");
    ack = 1'b1; step("R9 ack line 20");
    ex = 1'b1;  step("R9 exit top handler");
    rd_check(3'd4, "R9 exit cleared most urgent");
    ex = 1'b1;  step("R9 exit second handler");
    step("R7 idle presents lowest level");

    nmi = 1'b1; step("R3 nmi sampled");
    nmi = 1'b0; step("R3 nmi outranks");
    ack = 1'b1; step("R3 nmi ack");
    step("R3 nmi active blocks others");
    ack = 1'b1; step("R9 ack ignored with nothing presentable");
    ex = 1'b1;  step("R3 nmi exit");
    step("R3 external resumes");

    wr_cfg(3'd5, 32'h1 << 14, "R5 line 14 level");
    wr_cfg(3'd6, 32'hFFFF_FFFF & ~(32'h3 << 28) & ~(32'h3 << 2), "R5 prio lines 14 and 1");
    irq = N'(1) << 14; step("R5 level high");
    step("R5 level presented");
    ack = 1'b1; step("R5 ack level");
    step("R5 held high while active");
    rd_check(3'd2, "R5 no repend while active");
    ex = 1'b1; step("R5 exit with input high");
    step("R5 repend cycle");
    rd_check(3'd2, "R5 repend after exit");
    irq = '0;
    ack = 1'b1; step("R5 ack again");
    ex = 1'b1;  step("R5 exit with input low");
    rd_check(3'd2, "R5 no repend when low");

    irq = N'(1) << 1; step("R6 pulse line 1");
    irq = '0;         step("R6 presented");
    ack = 1'b1;       step("R6 ack");
    ex = 1'b1;        step("R6 exit");
    rd_check(3'd2, "R6 no repend without new pulse");
    irq = N'(1) << 1; step("R6 pulse again");
    irq = '0; ack = 1'b1; step("R6 ack again");
    irq = N'(1) << 1; step("R6 pulse while active");
    irq = '0; ex = 1'b1; step("R6 exit");
    rd_check(3'd2, "R6 repend after new pulse");

    irq = N'(1) << 1; wr_cfg(3'd3, 32'h2, "R8 clear with pulse");
    irq = '0;
    rd_check(3'd2, "R8 pulse beats clear");
    wr_cfg(3'd3, 32'h0000_000A, "R8 clear");
    rd_check(3'd2, "R8 clear takes effect");

    for (int c = 0; c < 4000; c++) begin
      logic ev, en; int eid;
      for (int i = 0; i < N; i++) irq[i] = ($urandom % 16) == 0;
      nmi = ($urandom % 64) == 0;
      if ($urandom % 8 == 0) begin
        wr = 1'b1; addr = 3'($urandom % 8); wdata = $urandom;
        if (addr == 3'd1 && ($urandom % 2 == 0)) wdata = '0;
      end
      m_present(ev, en, eid);
      ack = ev && ($urandom % 3 == 0);
      ex  = ($urandom % 6) == 0;
      step("R10 random presentation");
      if (c % 97 == 0) rd_check(3'($urandom % 8), "R12 random readback");
    end
    irq = '0; nmi = 1'b0;
    summary();
  end
endmodule